// File: doc/BRIEF.md
# Menu-Indexed Serial Flash Cycle Engine

This block is a serial flash master driven through a small word-addressed register window. Software does not place raw command bytes on the wire for every transfer. It loads a table of eight command bytes, a two-bit kind for each table slot, and two prefix command bytes. After that, each transfer is launched by a single control write that gives a slot number, the length of an optional data phase and an optional prefix request. The 24-bit flash address comes from an address register.

The engine builds the wire transaction from the kind of the chosen slot. An address-carrying kind adds three address bytes. A write kind sends bytes from the data buffer, and a read kind stores the returned bytes into the data buffer. When a prefix is requested, the prefix byte goes out alone in its own chip-select window, and a short idle gap follows before the main transaction. The data buffer is a bank of 32-bit words holding up to `MAX_BYTES` bytes. Status bits report busy, completion and misuse.

Register words, by word index (byte offset divided by 4):

- 0: status and control.
- 1: address.
- 2 onward: data buffer.
- 21: prefix bytes and slot kinds.
- 22 and 23: command table.

Top module: `spim_menu_ctrl`

## Requirements
- R1: Word 22 holds table slots 0–3 and word 23 holds slots 4–7, with slot i in byte lane i%4. Word 21 bits [15:0] hold prefix 0 in [7:0] and prefix 1 in [15:8]. Word 21 bits [31:16] hold the slot kinds, with slot i at bits [2i+17:2i+16]. Word 1 reads back its low 24 bits with bits [31:24] reading zero. All of these read back as written and read zero after reset.
- R2: A control write to word 0 with bit 17 set, while idle, starts a cycle. Its main transaction begins with the table byte of the slot in bits [22:20], sent MSB first inside one chip-select low window.
- R3: Slot kinds are 0 = read without address, 1 = write without address, 2 = read with address and 3 = write with address. Kinds 2 and 3 send address bits [23:16], [15:8] and [7:0] right after the command byte. Kinds 0 and 1 send no address.
- R4: For a write kind with the data phase enabled, the data bytes sent are buffer bytes 0 upward. Byte n lives in buffer word n/4, lane n%4 (bits [8*(n%4)+7 : 8*(n%4)]).
- R5: For a read kind with the data phase enabled, MOSI carries zero bytes during the data phase. Each returned byte n is stored at buffer byte n, using the same packing as R4.
- R6: Control bit 30 enables the data phase. Bits [29:24] give the byte count minus one, and only their low log2(`MAX_BYTES`) bits are used. With bit 30 clear, the transaction ends after the command and address bytes.
- R7: When bit 18 is set, the prefix selected by bit 19 (1 = prefix 1, 0 = prefix 0) goes out alone in its own chip-select window. Chip select then stays high for at least 2*`SCLK_DIV` clocks before the main transaction.
- R8: Status bit 0 reads 1 while a cycle runs. In the clock where it clears, bit 2 (done) sets. Writing 1 to bit 2 or bit 3 of word 0 clears that bit.
- R9: A start request while busy sets status bit 3 and neither starts a new cycle nor alters the running one. The start bit always reads back as 0.
- R10: The SPI uses mode 0. SCLK and CS_n idle at low and high respectively outside a cycle. MOSI changes only while SCLK is low, MISO is sampled on the rising edge, and the SCLK period is `SCLK_DIV` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_word | input | 5 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe, one clock per write |
| reg_rdata | output | 32 | Register read data for `reg_word`, combinational |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions take for granted that MISO only moves while SCLK is low, as a mode-0 flash would drive it. They also assume that software starts cycles with a single write to word 0 and issues at most one write strobe per clock. The bench's flash model updates MISO only on SCLK falling edges and at the fall of chip select. Buffer and address writes are made only while the engine is idle, and busy-time starts are issued only in the dedicated misuse test.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    OT_RD_NOADDR = 2'd0,
    OT_WR_NOADDR = 2'd1,
    OT_RD_ADDR   = 2'd2,
    OT_WR_ADDR   = 2'd3
  } optype_e;

  typedef enum logic [1:0] {
    PH_PRE  = 2'd0,
    PH_OP   = 2'd1,
    PH_ADDR = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;

  function automatic logic [7:0] menu_entry(input logic [63:0] m, input logic [2:0] i);
    return m[8*i +: 8];
  endfunction

  function automatic optype_e type_entry(input logic [15:0] t, input logic [2:0] i);
    return optype_e'(t[2*i +: 2]);
  endfunction

  function automatic logic has_addr(input optype_e t);
    return (t == OT_RD_ADDR) || (t == OT_WR_ADDR);
  endfunction

  function automatic logic is_write(input optype_e t);
    return (t == OT_WR_NOADDR) || (t == OT_WR_ADDR);
  endfunction

  function automatic logic [7:0] addr_byte(input logic [23:0] a, input logic [1:0] k);
    logic [7:0] r;
    case (k)
      2'd0:    r = a[23:16];
      2'd1:    r = a[15:8];
      default: r = a[7:0];
    endcase
    return r;
  endfunction

  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] l);
    return w[8*l +: 8];
  endfunction

endpackage

// File: rtl/spim_byte_shifter.sv
module spim_byte_shifter #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int HALF = DIV / 2;
  localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HC_W-1:0] hc;
  logic [2:0]      bitn;
  logic [7:0]      sh;
  logic            act;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc   <= '0;
      bitn <= '0;
      sh   <= '0;
      act  <= 1'b0;
      sclk <= 1'b0;
      done <= 1'b0;
      rx   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh   <= tx;
        act  <= 1'b1;
        hc   <= '0;
        bitn <= '0;
        sclk <= 1'b0;
      end else if (act) begin
        if (hc == HC_W'(HALF - 1)) begin
          hc <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitn == 3'd7) begin
              act  <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          hc <= hc + HC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spim_cycle_seq.sv
module spim_cycle_seq
  import spim_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_atomic,
  input  logic [7:0]       go_pre,
  input  logic [7:0]       go_op,
  input  optype_e          go_type,
  input  logic             go_den,
  input  logic [CNT_W-1:0] go_cnt,
  input  logic [23:0]      go_addr,
  input  logic [7:0]       wr_byte,
  input  logic             sh_done,
  output logic             cs_n,
  output logic             sh_start,
  output logic [7:0]       sh_tx,
  output logic             busy,
  output logic             fin,
  output logic             rx_we,
  output logic [CNT_W-1:0] bidx
);
  localparam int GAP_CLKS = 2 * DIV;
  localparam int GW       = $clog2(GAP_CLKS + 1);

  seq_state_e       st;
  phase_e           ph;
  logic [7:0]       pre_q, op_q;
  optype_e          type_q;
  logic             den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [23:0]      addr_q;
  logic [GW-1:0]    gcnt;
  logic [7:0]       byte_sel;
  logic             step;

  assign step = (st == ST_SHIFT) && sh_done;

  always_comb begin
    case (ph)
      PH_PRE:  byte_sel = pre_q;
      PH_OP:   byte_sel = op_q;
      PH_ADDR: byte_sel = addr_byte(addr_q, bidx[1:0]);
      default: byte_sel = is_write(type_q) ? wr_byte : 8'h00;
    endcase
  end

  always_comb begin
    fin = 1'b0;
    if (step) begin
      case (ph)
        PH_OP:   fin = !has_addr(type_q) && !den_q;
        PH_ADDR: fin = (bidx == CNT_W'(2)) && !den_q;
        PH_DATA: fin = (bidx == cnt_q);
        default: fin = 1'b0;
      endcase
    end
  end

  assign rx_we = step && (ph == PH_DATA) && !is_write(type_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_OP;
      pre_q    <= '0;
      op_q     <= '0;
      type_q   <= OT_RD_NOADDR;
      den_q    <= 1'b0;
      cnt_q    <= '0;
      addr_q   <= '0;
      gcnt     <= '0;
      bidx     <= '0;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      sh_start <= 1'b0;
      sh_tx    <= '0;
    end else begin
      sh_start <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          pre_q  <= go_pre;
          op_q   <= go_op;
          type_q <= go_type;
          den_q  <= go_den;
          cnt_q  <= go_cnt;
          addr_q <= go_addr;
          busy   <= 1'b1;
          cs_n   <= 1'b0;
          ph     <= go_atomic ? PH_PRE : PH_OP;
          bidx   <= '0;
          st     <= ST_LOAD;
        end
        ST_LOAD: begin
          sh_start <= 1'b1;
          sh_tx    <= byte_sel;
          st       <= ST_SHIFT;
        end
        ST_SHIFT: if (sh_done) begin
          if (fin) begin
            cs_n <= 1'b1;
            busy <= 1'b0;
            st   <= ST_IDLE;
          end else begin
            case (ph)
              PH_PRE: begin
                cs_n <= 1'b1;
                gcnt <= '0;
                st   <= ST_GAP;
              end
              PH_OP: begin
                ph   <= has_addr(type_q) ? PH_ADDR : PH_DATA;
                bidx <= '0;
                st   <= ST_LOAD;
              end
              PH_ADDR: begin
                if (bidx == CNT_W'(2)) begin
                  ph   <= PH_DATA;
                  bidx <= '0;
                end else begin
                  bidx <= bidx + CNT_W'(1);
                end
                st <= ST_LOAD;
              end
              default: begin
                bidx <= bidx + CNT_W'(1);
                st   <= ST_LOAD;
              end
            endcase
          end
        end
        default: begin
          if (gcnt == GW'(GAP_CLKS - 1)) begin
            cs_n <= 1'b0;
            ph   <= PH_OP;
            st   <= ST_LOAD;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spim_menu_ctrl.sv
module spim_menu_ctrl
  import spim_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int SCLK_DIV  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_word,
  input  logic [31:0] reg_wdata,
  input  logic        reg_we,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int NWORDS = MAX_BYTES / 4;
  localparam int CNT_W  = $clog2(MAX_BYTES);
  localparam int WIX_W  = CNT_W - 2;
  localparam logic [4:0] W_CTL  = 5'd0;
  localparam logic [4:0] W_ADDR = 5'd1;
  localparam logic [4:0] W_BUF0 = 5'd2;
  localparam logic [4:0] W_PFX  = 5'd21;
  localparam logic [4:0] W_MLO  = 5'd22;
  localparam logic [4:0] W_MHI  = 5'd23;

  logic [63:0]      menu_q;
  logic [15:0]      types_q;
  logic [15:0]      prefix_q;
  logic [23:0]      addr_q;
  logic             ctl_atomic, ctl_psel, ctl_den;
  logic [2:0]       ctl_idx;
  logic [CNT_W-1:0] ctl_cnt;
  logic             done_q, err_q;
  logic [31:0]      buf_q [NWORDS];

  logic             busy_w, fin_w, rx_we_w, start_req_w, go_w;
  logic             sh_start, sh_done;
  logic [7:0]       sh_tx, rx_byte, wr_byte;
  logic [CNT_W-1:0] didx;
  logic             ctl_wr, buf_hit;
  logic [WIX_W-1:0] buf_wix;
  logic [2:0]       go_idx;
  logic [5:0]       cnt_rd;

  assign ctl_wr      = reg_we && (reg_word == W_CTL);
  assign start_req_w = ctl_wr && reg_wdata[17];
  assign go_w        = start_req_w && !busy_w;
  assign go_idx      = reg_wdata[22:20];
  assign buf_hit     = (reg_word >= W_BUF0) && (reg_word < W_BUF0 + 5'(NWORDS));
  assign buf_wix     = WIX_W'(reg_word - W_BUF0);
  assign wr_byte     = lane_byte(buf_q[didx[CNT_W-1:2]], didx[1:0]);
  assign cnt_rd      = 6'(ctl_cnt);

  spim_cycle_seq #(.CNT_W(CNT_W), .DIV(SCLK_DIV)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go_w),
    .go_atomic(reg_wdata[18]),
    .go_pre   (reg_wdata[19] ? prefix_q[15:8] : prefix_q[7:0]),
    .go_op    (menu_entry(menu_q, go_idx)),
    .go_type  (type_entry(types_q, go_idx)),
    .go_den   (reg_wdata[30]),
    .go_cnt   (reg_wdata[24 +: CNT_W]),
    .go_addr  (addr_q),
    .wr_byte  (wr_byte),
    .sh_done  (sh_done),
    .cs_n     (spi_cs_n),
    .sh_start (sh_start),
    .sh_tx    (sh_tx),
    .busy     (busy_w),
    .fin      (fin_w),
    .rx_we    (rx_we_w),
    .bidx     (didx)
  );

  spim_byte_shifter #(.DIV(SCLK_DIV)) u_shf (
    .clk  (clk),
    .rst_n(rst_n),
    .start(sh_start),
    .tx   (sh_tx),
    .miso (spi_miso),
    .sclk (spi_sclk),
    .mosi (spi_mosi),
    .done (sh_done),
    .rx   (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      menu_q     <= '0;
      types_q    <= '0;
      prefix_q   <= '0;
      addr_q     <= '0;
      ctl_atomic <= 1'b0;
      ctl_psel   <= 1'b0;
      ctl_den    <= 1'b0;
      ctl_idx    <= '0;
      ctl_cnt    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (reg_we && !busy_w) begin
        case (reg_word)
          W_ADDR: addr_q <= reg_wdata[23:0];
          W_PFX:  {types_q, prefix_q} <= reg_wdata;
          W_MLO:  menu_q[31:0]  <= reg_wdata;
          W_MHI:  menu_q[63:32] <= reg_wdata;
          W_CTL: begin
            ctl_atomic <= reg_wdata[18];
            ctl_psel   <= reg_wdata[19];
            ctl_idx    <= reg_wdata[22:20];
            ctl_cnt    <= reg_wdata[24 +: CNT_W];
            ctl_den    <= reg_wdata[30];
          end
          default: ;
        endcase
      end
      if (fin_w)                        done_q <= 1'b1;
      else if (ctl_wr && reg_wdata[2])  done_q <= 1'b0;
      if (start_req_w && busy_w)        err_q  <= 1'b1;
      else if (ctl_wr && reg_wdata[3])  err_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWORDS; w++) buf_q[w] <= '0;
    end else if (rx_we_w) begin
      buf_q[didx[CNT_W-1:2]][8*didx[1:0] +: 8] <= rx_byte;
    end else if (reg_we && buf_hit && !busy_w) begin
      buf_q[buf_wix] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_word)
      W_CTL:  reg_rdata = {1'b0, ctl_den, cnt_rd, 1'b0, ctl_idx, ctl_psel, ctl_atomic,
                           2'b00, 12'h000, err_q, done_q, 1'b0, busy_w};
      W_ADDR: reg_rdata = {8'h00, addr_q};
      W_PFX:  reg_rdata = {types_q, prefix_q};
      W_MLO:  reg_rdata = menu_q[31:0];
      W_MHI:  reg_rdata = menu_q[63:32];
      default: if (buf_hit) reg_rdata = buf_q[buf_wix];
    endcase
  end
endmodule

// File: rtl/spim_menu_ctrl_chk.sv
module spim_menu_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic done_flag,
  input logic err_flag,
  input logic start_req,
  input logic rx_we,
  input logic fin
);
  // R8: completion shows done in the same clock busy drops
  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  // R8: a finishing step leaves the engine idle with done set
  a_r8_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!busy && done_flag));

  // R9: start during a cycle flags an error
  a_r9_busy_start_err: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && busy) |=> err_flag);

  // R10: chip select stays high while idle
  a_r10_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  // R10: SCLK idles low outside a transaction
  a_r10_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R10: MOSI holds while SCLK is high
  a_r10_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  // R5: returned bytes are stored only inside a cycle
  a_r5_rx_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (busy && !cs_n));
endmodule

bind spim_menu_ctrl spim_menu_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy_w),
  .cs_n     (spi_cs_n),
  .sclk     (spi_sclk),
  .mosi     (spi_mosi),
  .done_flag(done_q),
  .err_flag (err_q),
  .start_req(start_req_w),
  .rx_we    (rx_we_w),
  .fin      (fin_w)
);

// File: tb/spim_menu_ctrl_tb.sv
`timescale 1ns/1ps
module spim_menu_ctrl_tb;
  localparam int MAXB = 64;
  localparam int DIV  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_word = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spim_menu_ctrl #(.MAX_BYTES(MAXB), .SCLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_word(reg_word), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // flash model: frame capture, MISO pattern, gap and period measurement
  logic [7:0] fbuf [4][72];
  int  flen [4];
  int  fgap [4];
  int  nfr = 0, bitc = 0, bytepos = 0, gap_cnt = 0, since = 0, min_per = 1000;
  bit  in_frame = 0, sclk_prev = 0;
  logic [7:0] shin = '0;
  logic [7:0] miso_seed = 8'h00;

  function automatic logic [7:0] pat(input int p);
    return 8'(p * 29) ^ miso_seed ^ 8'hA6;
  endfunction

  always @(negedge spi_cs_n) begin
    in_frame = 1;
    fgap[nfr % 4] = gap_cnt;
    flen[nfr % 4] = 0;
    bitc = 0;
    bytepos = 0;
    spi_miso = pat(0)[7];
  end
  always @(posedge spi_cs_n) if (in_frame) begin
    in_frame = 0;
    nfr++;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    shin = {shin[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      if (flen[nfr % 4] < 72) fbuf[nfr % 4][flen[nfr % 4]] = shin;
      flen[nfr % 4]++;
      bitc = 0;
      bytepos++;
    end
  end
  always @(negedge spi_sclk) if (!spi_cs_n) spi_miso = pat(bytepos)[7 - bitc];
  always @(posedge clk) if (spi_cs_n) gap_cnt++; else gap_cnt = 0;
  always @(negedge clk) begin
    since++;
    if (spi_sclk && !sclk_prev) begin
      if (since < min_per) min_per = since;
      since = 0;
    end
    sclk_prev = spi_sclk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] w, input logic [31:0] d);
    @(negedge clk);
    reg_word = w; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] w, output logic [31:0] d);
    @(negedge clk);
    reg_word = w; reg_we = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output logic [31:0] d);
    int n = 0;
    do begin
      reg_rd(5'd0, d);
      n++;
    end while (!d[2] && n < 40000);
  endtask

  logic [7:0] menu_m [8];
  logic [1:0] type_m [8];
  logic [7:0] pre_m  [2];
  logic [7:0] wb [MAXB];

  function automatic int find_idx(input logic [1:0] t);
    for (int i = 0; i < 8; i++) if (type_m[i] == t) return i;
    return 0;
  endfunction

  function automatic logic [31:0] ctl_word(input int idx, input bit atom, input bit ps,
                                           input bit den, input int cm1);
    return (32'd1 << 17) | (32'(atom) << 18) | (32'(ps) << 19) | (32'(idx) << 20) |
           (32'(cm1 & (MAXB - 1)) << 24) | (32'(den) << 30);
  endfunction

  task automatic run_cycle(input int idx, input bit atom, input bit ps, input bit den,
                           input int cm1, input logic [31:0] adr);
    int base, hdr, mf, explen, bad;
    logic [31:0] rd;
    logic [1:0] t;
    t = type_m[idx];
    if (den && t[0]) begin
      for (int j = 0; j <= cm1; j++) wb[j] = 8'($urandom);
      for (int w = 0; w <= cm1 / 4; w++)
        reg_wr(5'(2 + w), {wb[4*w+3], wb[4*w+2], wb[4*w+1], wb[4*w]});
    end
    reg_wr(5'd1, adr);
    miso_seed = 8'($urandom);
    min_per = 1000;
    base = nfr;
    reg_wr(5'd0, ctl_word(idx, atom, ps, den, cm1));
    wait_done(rd);
    mf = (base + (atom ? 1 : 0)) % 4;
    hdr = 1 + (t[1] ? 3 : 0);
    explen = hdr + (den ? cm1 + 1 : 0);
    chk("R7 frame count", nfr - base, atom ? 2 : 1);
    if (atom) begin
      chk("R7 prefix frame length", flen[base % 4], 1);
      chk("R7 prefix byte", 32'(fbuf[base % 4][0]), 32'(pre_m[ps]));
      chk("R7 gap", 32'(fgap[mf] >= 2 * DIV), 1);
    end
    chk("R2 command byte", 32'(fbuf[mf][0]), 32'(menu_m[idx]));
    chk("R6 transaction length", flen[mf], explen);
    if (t[1]) chk("R3 address bytes", {8'h00, fbuf[mf][1], fbuf[mf][2], fbuf[mf][3]}, {8'h00, adr[23:0]});
    if (den) begin
      bad = 0;
      if (t[0]) begin
        for (int j = 0; j <= cm1; j++) if (fbuf[mf][hdr + j] !== wb[j]) bad++;
        chk("R4 write data mismatches", bad, 0);
      end else begin
        for (int j = 0; j <= cm1; j++) if (fbuf[mf][hdr + j] !== 8'h00) bad++;
        chk("R5 MOSI zero during read", bad, 0);
        bad = 0;
        for (int j = 0; j <= cm1; j++) begin
          logic [31:0] w;
          reg_rd(5'(2 + j / 4), w);
          if (w[8*(j%4) +: 8] !== pat(hdr + j)) bad++;
        end
        chk("R5 read buffer mismatches", bad, 0);
      end
    end
    chk("R8 status after cycle", {16'h0, rd[15:0]}, 32'h0000_0004);
    chk("R9 start reads zero", {31'h0, rd[17]}, 0);
    chk("R10 SCLK period", min_per, DIV);
    reg_wr(5'd0, 32'h0000_000C);
    reg_rd(5'd0, rd);
    chk("R8 status after clear", {16'h0, rd[15:0]}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int r, base, idx;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    reg_rd(5'd0, rd);  chk("R8 reset status", rd, 0);
    reg_rd(5'd22, rd); chk("R1 reset table", rd, 0);
    reg_rd(5'd21, rd); chk("R1 reset kinds", rd, 0);
    chk("R10 idle lines", {30'h0, spi_cs_n, spi_sclk}, 32'h2);

    r = int'($urandom % 4);
    for (int i = 0; i < 8; i++) begin
      menu_m[i] = 8'($urandom);
      type_m[i] = 2'(i + r);
    end
    pre_m[0] = 8'($urandom);
    pre_m[1] = 8'($urandom);
    reg_wr(5'd22, {menu_m[3], menu_m[2], menu_m[1], menu_m[0]});
    reg_wr(5'd23, {menu_m[7], menu_m[6], menu_m[5], menu_m[4]});
    reg_wr(5'd21, {type_m[7], type_m[6], type_m[5], type_m[4], type_m[3], type_m[2],
                   type_m[1], type_m[0], pre_m[1], pre_m[0]});
    reg_rd(5'd22, rd); chk("R1 table low", rd, {menu_m[3], menu_m[2], menu_m[1], menu_m[0]});
    reg_rd(5'd23, rd); chk("R1 table high", rd, {menu_m[7], menu_m[6], menu_m[5], menu_m[4]});
    reg_rd(5'd21, rd); chk("R1 prefix and kinds", rd,
      {type_m[7], type_m[6], type_m[5], type_m[4], type_m[3], type_m[2],
       type_m[1], type_m[0], pre_m[1], pre_m[0]});
    reg_wr(5'd1, 32'hFFAB_CDEF);
    reg_rd(5'd1, rd); chk("R1 address upper byte", rd, 32'h00AB_CDEF);

    // directed corners
    run_cycle(find_idx(2'd2), 0, 0, 1, MAXB - 1, $urandom);
    run_cycle(find_idx(2'd3), 1, 1, 1, 0, $urandom);
    run_cycle(find_idx(2'd3), 1, 0, 0, 0, $urandom);
    run_cycle(find_idx(2'd0), 0, 0, 1, 3, $urandom);
    run_cycle(find_idx(2'd1), 0, 0, 1, 5, $urandom);
    run_cycle(find_idx(2'd2), 0, 0, 0, 0, $urandom);
    reg_wr(5'd0, ctl_word(2, 1, 1, 1, 9) & ~(32'd1 << 17));
    reg_rd(5'd0, rd);
    chk("R9 control readback without start", rd, ctl_word(2, 1, 1, 1, 9) & ~(32'd1 << 17));

    // R9: start while busy
    idx = find_idx(2'd2);
    base = nfr;
    reg_wr(5'd0, ctl_word(idx, 0, 0, 1, MAXB - 1));
    reg_wr(5'd0, ctl_word((idx + 1) % 8, 1, 0, 1, 0));
    reg_rd(5'd0, rd);
    chk("R9 error and busy set", {28'h0, rd[3:0] & 4'b1001}, 32'h9);
    wait_done(rd);
    chk("R9 one frame only", nfr - base, 1);
    chk("R9 running command kept", 32'(fbuf[base % 4][0]), 32'(menu_m[idx]));
    chk("R9 running length kept", flen[base % 4], 4 + MAXB);
    reg_wr(5'd0, 32'h0000_0008);
    reg_rd(5'd0, rd);
    chk("R8 error cleared, done kept", {16'h0, rd[15:0]}, 32'h4);
    reg_wr(5'd0, 32'h0000_0004);

    // random cycles
    for (int k = 0; k < 16; k++) begin
      int cm;
      cm = ($urandom % 4 == 0) ? MAXB - 1 : int'($urandom % 12);
      run_cycle(int'($urandom % 8), bit'($urandom), bit'($urandom), bit'($urandom % 4 != 0),
                cm, $urandom);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule